// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and date: seconds, minutes, hours, a day-of-week index, day of month, month and a three-digit year. A free-running divider counts cycles of the 32768 Hz clock and produces one advance per second. Each advance steps the seconds. Carries ripple through minutes, hours, the date and the year. Month lengths and the Gregorian leap-year rule are applied.

All fields are held internally in binary. Every field is visible at the outputs at all times as BCD. Software-side logic loads a field by presenting a field code, BCD data and a write strobe. A load is accepted only while the run input is high. While run is low the whole calendar is frozen and loads are ignored. The first second after run rises takes a full divider period. Loading the seconds field also restarts the divider phase.

Top module: `bcd_calendar`

## Requirements
- R1: With run held high, the seconds field advances exactly once every DIVISOR cycles. When run is first sampled high at a clock edge, the divider restarts, and the first advance lands on the DIVISOR-th edge after that one.
- R2: Seconds and minutes count 00..59 and hours count 00..23. When a field wraps to 00, the next field up advances by one.
- R3: The day-of-week output counts 0..6. It advances by one on each hours wrap (midnight), goes from 6 back to 0, and does not depend on the date.
- R4: Day of month wraps to 01 after the last day of the month, and the month then advances. Month lengths are 31, 28/29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 for months 1..12. A month code outside 1..12 is treated as 31 days. Moving on from month 12 gives month 01 and increments the year. Year 999 is followed by year 000.
- R5: February has 29 days when the year value y (read as calendar year 2000+y) is a leap year: divisible by 400, or divisible by 4 and not by 100. So years 000, 024 and 400 are leap years and year 100 is not.
- R6: Field codes on wr_sel are: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day of month, 5 month, 6 year, 7 no field. Two-digit fields take BCD in wr_data[7:4] (tens) and wr_data[3:0] (units). Month is given and shown as 01..12. Year takes tens and units in wr_data[7:0] and hundreds in wr_data[11:8]. year_bcd uses the same layout. An accepted load is visible on the outputs after the next clock edge.
- R7: While run is low, no field changes: neither loads nor time advances.
- R8: A load of seconds restarts the divider, so the next advance comes DIVISOR edges after the load edge. Loads of other fields keep the current phase. If such a load coincides with an advance, the loaded field takes the loaded value and the other fields advance.
- R9: A day of month of 00 becomes 01 at the next midnight, and the month does not change.
- R10: After reset the outputs show 00:00:00, day-of-week 0, day 01, month 01, year 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Global enable: counting and loads |
| wr_en | input | 1 | Load strobe for the selected field |
| wr_sel | input | 3 | Field code (see R6) |
| wr_data | input | 12 | BCD load value |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| wday_bcd | output | 8 | Day-of-week 0..6, BCD |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month 01..12, BCD |
| year_bcd | output | 12 | Three-digit year, BCD |

## Verification
Directed cases place the clock one second before midnight on month ends. They cover February in years 000, 024, 100 and 400, April 30th, December 31st of year 999 and a zero day of month. This separates the leap rule, the month table, the year wrap and the zero-day fix-up from the plain carry chain. Sequences with run dropped and loads attempted separate a frozen calendar from one that counts or accepts data. Loads of seconds versus minutes in mid-phase separate restarting the divider from keeping its phase. A long random run mixes loads, enable toggles and counting, so loads that coincide with advances are exercised against the bench's cycle model.

// File: rtl/cal_pkg.sv
// Shared types and conversion helpers for the BCD calendar.
// Assumes BCD inputs are two 4-bit digits. Out-of-range digits convert
// arithmetically, without saturation.
package cal_pkg;

    localparam int NUM_PAIR = 6;

    typedef enum logic [2:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_WDAY = 3'd3,
        SEL_MDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6,
        SEL_NONE = 3'd7
    } field_sel_e;

    typedef struct packed {
        logic [10:0] year;
        logic [7:0]  mon;
        logic [7:0]  mday;
        logic [7:0]  wday;
        logic [7:0]  hour;
        logic [7:0]  min;
        logic [7:0]  sec;
    } cal_time_t;

    // Two BCD digits to binary.
    function automatic logic [7:0] bcd2bin8(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    // Binary to two BCD digits.
    function automatic logic [7:0] bin2bcd8(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Gregorian rule applied to the stored year (its base is a multiple of 400).
    function automatic logic is_leap(input logic [10:0] y);
        logic by4, by100, by400;
        by4   = (y % 11'd4)   == 11'd0;
        by100 = (y % 11'd100) == 11'd0;
        by400 = (y % 11'd400) == 11'd0;
        return by400 || (by4 && !by100);
    endfunction

    // Length of a 1-based month. Unknown month codes count as 31 days.
    function automatic logic [7:0] days_in_month(input logic [7:0] m, input logic leap);
        case (m)
            8'd2:                      return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_timebase.sv
// Seconds divider: raises tick for one cycle every DIVISOR enabled cycles.
// Assumes DIVISOR >= 2. Reloads to a full count on the first enabled
// cycle after a disabled one, and whenever reload is asserted.
module cal_timebase #(
    parameter int DIVISOR = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic reload,
    output logic tick
);
    localparam int CW = (DIVISOR > 2) ? $clog2(DIVISOR) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIVISOR - 1);

    logic [CW-1:0] cnt;
    logic          run_q;

    // Down-counter with restart on enable rise or on seconds load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= LAST;
            run_q <= 1'b0;
        end else begin
            run_q <= run;
            if (run) begin
                if (!run_q || reload || cnt == '0) begin
                    cnt <= LAST;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // One-cycle advance strobe when an enabled count expires.
    always_comb begin
        tick = run && run_q && !reload && (cnt == '0);
    end

endmodule

// File: rtl/cal_cascade.sv
// Calendar registers with the carry cascade and load override.
// Assumes tick is only raised while counting is enabled and that wr_ok
// already includes the enable. A load replaces the stepped value of its field.
module cal_cascade
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_ok,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    output cal_time_t   now_o
);
    cal_time_t  cur;
    cal_time_t  stepped;
    cal_time_t  nxt;
    logic       c_min, c_hour, c_day;
    logic       c_mon, c_year;
    logic [7:0] dim;
    logic [7:0] wr_bin;
    logic [10:0] wr_year;

    // Carries through seconds, minutes and hours.
    always_comb begin
        c_min  = tick && (cur.sec  >= 8'd59);
        c_hour = c_min  && (cur.min  >= 8'd59);
        c_day  = c_hour && (cur.hour >= 8'd23);
        dim    = days_in_month(cur.mon, is_leap(cur.year));
    end

    // Next value of every field when a second elapses.
    always_comb begin
        stepped = cur;
        c_mon   = 1'b0;
        c_year  = 1'b0;
        if (tick) begin
            stepped.sec = c_min ? 8'd0 : cur.sec + 8'd1;
        end
        if (c_min) begin
            stepped.min = c_hour ? 8'd0 : cur.min + 8'd1;
        end
        if (c_hour) begin
            stepped.hour = c_day ? 8'd0 : cur.hour + 8'd1;
        end
        if (c_day) begin
            stepped.wday = (cur.wday >= 8'd6) ? 8'd0 : cur.wday + 8'd1;
            if (cur.mday == 8'd0) begin
                stepped.mday = 8'd1;
            end else if (cur.mday >= dim) begin
                stepped.mday = 8'd1;
                c_mon        = 1'b1;
            end else begin
                stepped.mday = cur.mday + 8'd1;
            end
        end
        if (c_mon) begin
            if (cur.mon >= 8'd12) begin
                stepped.mon = 8'd1;
                c_year      = 1'b1;
            end else begin
                stepped.mon = cur.mon + 8'd1;
            end
        end
        if (c_year) begin
            stepped.year = (cur.year >= 11'd999) ? 11'd0 : cur.year + 11'd1;
        end
    end

    // Converted load values.
    always_comb begin
        wr_bin  = bcd2bin8(wr_data[7:0]);
        wr_year = 11'(wr_bin) + (11'(wr_data[11:8]) * 11'd100);
    end

    // Accepted load overrides the stepped value of one field.
    always_comb begin
        nxt = stepped;
        if (wr_ok) begin
            case (wr_sel)
                SEL_SEC:  nxt.sec  = wr_bin;
                SEL_MIN:  nxt.min  = wr_bin;
                SEL_HOUR: nxt.hour = wr_bin;
                SEL_WDAY: nxt.wday = wr_bin;
                SEL_MDAY: nxt.mday = wr_bin;
                SEL_MON:  nxt.mon  = wr_bin;
                SEL_YEAR: nxt.year = wr_year;
                default:  nxt      = stepped;
            endcase
        end
    end

    // Calendar state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '{year: 11'd0, mon: 8'd1, mday: 8'd1, wday: 8'd0,
                     hour: 8'd0, min: 8'd0, sec: 8'd0};
        end else begin
            cur <= nxt;
        end
    end

    assign now_o = cur;

endmodule

// File: rtl/cal_readout.sv
// Binary-to-BCD view of the calendar state. Purely combinational.
// Assumes two-digit fields stay below 100 and the year below 1000 in normal use.
module cal_readout
    import cal_pkg::*;
(
    input  cal_time_t   t,
    output logic [7:0]  sec_bcd,
    output logic [7:0]  min_bcd,
    output logic [7:0]  hour_bcd,
    output logic [7:0]  wday_bcd,
    output logic [7:0]  mday_bcd,
    output logic [7:0]  mon_bcd,
    output logic [11:0] year_bcd
);
    logic [7:0]  pair_bin [NUM_PAIR];
    logic [7:0]  pair_bcd [NUM_PAIR];
    logic [10:0] y_mod;
    logic [10:0] y_low;
    logic [10:0] y_hund;

    // Gather the two-digit fields in a fixed order.
    always_comb begin
        pair_bin[0] = t.sec;
        pair_bin[1] = t.min;
        pair_bin[2] = t.hour;
        pair_bin[3] = t.wday;
        pair_bin[4] = t.mday;
        pair_bin[5] = t.mon;
    end

    // One converter per two-digit field.
    for (genvar i = 0; i < NUM_PAIR; i++) begin : g_pair
        always_comb begin
            pair_bcd[i] = bin2bcd8(pair_bin[i]);
        end
    end

    // Split the year into hundreds and the two low digits.
    always_comb begin
        y_mod  = t.year % 11'd1000;
        y_low  = y_mod % 11'd100;
        y_hund = y_mod / 11'd100;
    end

    // Drive the outputs.
    always_comb begin
        sec_bcd  = pair_bcd[0];
        min_bcd  = pair_bcd[1];
        hour_bcd = pair_bcd[2];
        wday_bcd = pair_bcd[3];
        mday_bcd = pair_bcd[4];
        mon_bcd  = pair_bcd[5];
        year_bcd = {y_hund[3:0], bin2bcd8(y_low[7:0])};
    end

endmodule

// File: rtl/bcd_calendar.sv
// Top level of the BCD calendar counter: divider, cascade and BCD view.
// Assumes clk is the counting clock and DIVISOR >= 2 (32768 for one second).
// Loads are accepted only while run is high.
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int DIVISOR = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    output logic [7:0]  sec_bcd,
    output logic [7:0]  min_bcd,
    output logic [7:0]  hour_bcd,
    output logic [7:0]  wday_bcd,
    output logic [7:0]  mday_bcd,
    output logic [7:0]  mon_bcd,
    output logic [11:0] year_bcd
);
    logic      wr_ok;
    logic      sec_load;
    logic      sec_tick;
    cal_time_t now;

    // Gate loads with the global enable and spot seconds loads.
    always_comb begin
        wr_ok    = wr_en && run;
        sec_load = wr_ok && (wr_sel == SEL_SEC);
    end

    cal_timebase #(.DIVISOR(DIVISOR)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (sec_load),
        .tick   (sec_tick)
    );

    cal_cascade u_casc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .wr_ok   (wr_ok),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .now_o   (now)
    );

    cal_readout u_view (
        .t        (now),
        .sec_bcd  (sec_bcd),
        .min_bcd  (min_bcd),
        .hour_bcd (hour_bcd),
        .wday_bcd (wday_bcd),
        .mday_bcd (mday_bcd),
        .mon_bcd  (mon_bcd),
        .year_bcd (year_bcd)
    );

endmodule

// File: rtl/cal_checker.sv
// Temporal checks on the calendar ports and the divider strobe.
// Assumes reset is asserted at the first clock edge.
module cal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        wr_en,
    input logic        tick,
    input logic [7:0]  sec_bcd,
    input logic [7:0]  min_bcd,
    input logic [7:0]  hour_bcd,
    input logic [7:0]  wday_bcd,
    input logic [7:0]  mday_bcd,
    input logic [7:0]  mon_bcd,
    input logic [11:0] year_bcd
);
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    AST_RISE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |=> !tick); // R1
    AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(sec_bcd)); // R1
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec_bcd == 8'h59) |=> (sec_bcd == 8'h00)); // R2
    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec_bcd == 8'h59) |=> (min_bcd != $past(min_bcd))); // R2
    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec_bcd == 8'h59 && min_bcd == 8'h59 &&
         hour_bcd == 8'h23 && wday_bcd == 8'h06) |=> (wday_bcd == 8'h00)); // R3
    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(sec_bcd) && $stable(min_bcd) && $stable(hour_bcd) &&
                  $stable(wday_bcd) && $stable(mday_bcd) && $stable(mon_bcd) &&
                  $stable(year_bcd))); // R7
endmodule

bind bcd_calendar cal_checker u_cal_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .wr_en    (wr_en),
    .tick     (sec_tick),
    .sec_bcd  (sec_bcd),
    .min_bcd  (min_bcd),
    .hour_bcd (hour_bcd),
    .wday_bcd (wday_bcd),
    .mday_bcd (mday_bcd),
    .mon_bcd  (mon_bcd),
    .year_bcd (year_bcd)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd7;
    logic [11:0] wr_data = '0;
    logic [7:0]  sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd;
    logic [11:0] year_bcd;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state (binary, month 1-based)
    int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year;
    int m_cnt;
    bit m_run_prev;

    always #5 clk = ~clk;

    bcd_calendar #(.DIVISOR(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
        .hour_bcd(hour_bcd), .wday_bcd(wday_bcd), .mday_bcd(mday_bcd),
        .mon_bcd(mon_bcd), .year_bcd(year_bcd)
    );

    function automatic logic [7:0] tb_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int tb_unbcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int tb_month_len(input int mo, input int yr);
        int cy;
        bit lp;
        cy = 2000 + yr;
        lp = ((cy % 4 == 0) && (cy % 100 != 0)) || (cy % 400 == 0);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hour++;
        if (m_hour < 24) return;
        m_hour = 0;
        m_wday = (m_wday + 1) % 7;
        if (m_mday == 0) begin
            m_mday = 1;
        end else if (m_mday + 1 > tb_month_len(m_mon, m_year)) begin
            m_mday = 1;
            if (m_mon == 12) begin
                m_mon = 1;
                m_year = (m_year == 999) ? 0 : m_year + 1;
            end else begin
                m_mon++;
            end
        end else begin
            m_mday++;
        end
    endtask

    task automatic model_load(input logic [2:0] s, input logic [11:0] d);
        case (s)
            3'd0: m_sec  = tb_unbcd(d[7:0]);
            3'd1: m_min  = tb_unbcd(d[7:0]);
            3'd2: m_hour = tb_unbcd(d[7:0]);
            3'd3: m_wday = tb_unbcd(d[7:0]);
            3'd4: m_mday = tb_unbcd(d[7:0]);
            3'd5: m_mon  = tb_unbcd(d[7:0]);
            3'd6: m_year = tb_unbcd(d[7:0]) + 100 * int'(d[11:8]);
            default: ;
        endcase
    endtask

    // Drive one cycle (from a negedge), update the model, return at the next negedge.
    task automatic step(input bit r, input bit w, input logic [2:0] s, input logic [11:0] d);
        bit tk;
        run = r; wr_en = w; wr_sel = s; wr_data = d;
        @(posedge clk);
        tk = 1'b0;
        if (r) begin
            if (!m_run_prev || (w && s == 3'd0)) m_cnt = DIV - 1;
            else if (m_cnt == 0) begin tk = 1'b1; m_cnt = DIV - 1; end
            else m_cnt--;
            if (tk) model_second();
            if (w) model_load(s, d);
        end
        m_run_prev = r;
        @(negedge clk);
    endtask

    task automatic check(input string tag);
        logic [59:0] got, exp;
        got = {year_bcd, mon_bcd, mday_bcd, wday_bcd, hour_bcd, min_bcd, sec_bcd};
        exp = {tb_bcd(m_year / 100)[3:0], tb_bcd(m_year % 100), tb_bcd(m_mon),
               tb_bcd(m_mday), tb_bcd(m_wday), tb_bcd(m_hour), tb_bcd(m_min),
               tb_bcd(m_sec)};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_checked(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 3'd7, 12'h000);
            check(tag);
        end
    endtask

    task automatic load(input logic [2:0] s, input logic [11:0] d);
        step(1'b1, 1'b1, s, d);
        check("R6");
    endtask

    // Loads all fields, seconds last so the phase restarts.
    task automatic set_time(input logic [11:0] y, input logic [7:0] mo, input logic [7:0] dd,
                            input logic [7:0] wd, input logic [7:0] h, input logic [7:0] mi,
                            input logic [7:0] s);
        load(3'd6, y);
        load(3'd5, {4'h0, mo});
        load(3'd4, {4'h0, dd});
        load(3'd3, {4'h0, wd});
        load(3'd2, {4'h0, h});
        load(3'd1, {4'h0, mi});
        load(3'd0, {4'h0, s});
    endtask

    function automatic logic [11:0] rand_field(input logic [2:0] s);
        int v;
        case (s)
            3'd0, 3'd1: v = $urandom_range(59);
            3'd2: v = $urandom_range(23);
            3'd3: v = $urandom_range(6);
            3'd4: v = $urandom_range(28, 1);
            3'd5: v = $urandom_range(12, 1);
            default: v = $urandom_range(999);
        endcase
        if (s == 3'd6) return {tb_bcd(v / 100)[3:0], tb_bcd(v % 100)};
        return {4'h0, tb_bcd(v)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_mday = 1; m_mon = 1; m_year = 0;
        m_cnt = DIV - 1; m_run_prev = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10");

        // R1: first advance DIVISOR edges after run rises, then every DIVISOR
        run_checked(3 * DIV + 2, "R1");

        // R2: minute and hour carries
        set_time(12'h024, 8'h06, 8'h15, 8'h02, 8'h22, 8'h58, 8'h59);
        run_checked(DIV + 1, "R2");
        set_time(12'h024, 8'h06, 8'h15, 8'h02, 8'h22, 8'h59, 8'h59);
        run_checked(DIV + 1, "R2");

        // R5 and R3: leap February, weekday wrap 6 to 0
        set_time(12'h024, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h59);
        run_checked(DIV + 1, "R5");
        set_time(12'h100, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_checked(DIV + 1, "R5");
        set_time(12'h000, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        run_checked(DIV + 1, "R5");
        set_time(12'h400, 8'h02, 8'h29, 8'h05, 8'h23, 8'h59, 8'h59);
        run_checked(DIV + 1, "R3");

        // R4: month end and year wrap
        set_time(12'h123, 8'h04, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59);
        run_checked(DIV + 1, "R4");
        set_time(12'h999, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
        run_checked(DIV + 1, "R4");

        // R9: zero day of month
        set_time(12'h050, 8'h05, 8'h00, 8'h00, 8'h23, 8'h59, 8'h59);
        run_checked(DIV + 1, "R9");

        // R7: frozen and deaf while run is low
        step(1'b0, 1'b0, 3'd7, 12'h000); check("R7");
        for (int s = 0; s < 7; s++) begin
            step(1'b0, 1'b1, 3'(s), 12'h321);
            check("R7");
        end
        for (int i = 0; i < 2 * DIV; i++) begin
            step(1'b0, 1'b0, 3'd7, 12'h000);
            check("R7");
        end
        run_checked(DIV + 1, "R1");

        // R8: minute load keeps the phase, seconds load restarts it
        step(1'b1, 1'b1, 3'd1, 12'h017); check("R8");
        run_checked(DIV, "R8");
        run_checked(DIV / 2, "R8");
        step(1'b1, 1'b1, 3'd0, 12'h030); check("R8");
        run_checked(DIV + 1, "R8");

        // Random mix of loads, enable toggles and counting
        for (int i = 0; i < 3000; i++) begin
            bit r, w;
            logic [2:0] s;
            r = ($urandom_range(15) != 0);
            w = ($urandom_range(7) == 0);
            s = 3'($urandom_range(6));
            step(r, w, s, rand_field(s));
            check(w ? "R6" : "R2");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule